// File: doc/BRIEF.md
# Multiplexed host port with event-latched status

This block connects an 8-bit host bus, on which address and data share the same wires, to a small register file. A static strap input picks one of two bus timing styles. In the first style there are separate active-low read and write strobes. In the second there is one active-high data strobe and a read/write direction line. In both styles the address is taken from the shared bus when the address strobe falls. A write takes effect when its strobe ends. During a read, the block drives the shared bus from the cycle after the strobe becomes active until the cycle after it ends.

The datapath reports events to two status registers as one-cycle strobes, one strobe per bit. Each event sets a latch bit. Software never sees the latch bits directly. It sees a readable copy of them, which it refreshes by writing a mask byte to the status register:
- For each bit written as one, the copy takes the bit's current value and the latch for that bit is cleared.
- For each bit written as zero, the copy keeps its old value.

This lets software poll single bits without disturbing the others. A third status register shows a real-time status word without latching; it needs no preceding write. Each of the two latched registers drives its own active-low interrupt output, and a mask register for each one gates which latched bits can raise it.

Top module: `hostport_top`

## Requirements
- R1: After reset, `ad_oe` is 0, both interrupt outputs are 1, both readable status copies and both mask registers read 0x00.
- R2: The register address is the value on `ad_in` at the clock edge where `ale` is first seen low after being high. Later changes on `ad_in` do not change which register is accessed. The register map is: 0x00 status A, 0x01 status B, 0x02 interrupt mask A, 0x03 interrupt mask B, 0x04 real-time status. Every other address reads 0x00 and ignores writes.
- R3: With `bus_mode`=0, a read is `rd_n_ds`=0 and a write is `wr_n_rw`=0. With `bus_mode`=1, a strobe is `rd_n_ds`=1, and `wr_n_rw`=1 marks a read while `wr_n_rw`=0 marks a write. In both modes a strobe counts only while `cs_n`=0. A write commits the data last seen during the strobe, at the edge where the strobe is first seen inactive. A read never modifies a register.
- R4: `ad_oe` rises one clock after a read strobe is first active. It falls one clock after the strobe ends. While it is high, `ad_out` carries the addressed register.
- R5: An event strobe sets its latch bit, and the bit stays set until a mask write clears it.
- R6: A write to a status register sets the copy bit to the latch's value for every bit written as one, and clears that latch. Bits written as zero keep their previous copy value.
- R7: An event that is present in the clearing cycle sets the latch again, so a later mask write reads it as one.
- R8: A read of the real-time status register returns the live `rt_status` value, with no preceding write.
- R9: An interrupt output is 0 while any latched bit of its register has its mask bit set. It returns to 1 once all such bits are cleared or masked.
- R10: Status B and mask B have 6 valid bits. Bits 7:6 of these registers read 0, and writes to those bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; all bus inputs are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 1 | Timing strap: 0 separate read/write strobes, 1 data strobe with direction |
| cs_n | input | 1 | Active-low chip select |
| ale | input | 1 | Address strobe; address is captured on its falling edge |
| rd_n_ds | input | 1 | Read strobe (mode 0, active low) or data strobe (mode 1, active high) |
| wr_n_rw | input | 1 | Write strobe (mode 0, active low) or direction (mode 1, 1 = read) |
| ad_in | input | 8 | Shared address/data bus, input side |
| ad_out | output | 8 | Shared bus, output side |
| ad_oe | output | 1 | Output enable for the shared bus |
| evt_a | input | 8 | Event strobes for status register A |
| evt_b | input | 6 | Event strobes for status register B |
| rt_status | input | 8 | Real-time status word |
| irq_a_n | output | 1 | Active-low interrupt for status register A |
| irq_b_n | output | 1 | Active-low interrupt for status register B |

## Verification
The hardest case to reach is an event that arrives in the same clock as the mask write that clears it. That edge is where the bus write commits, and it comes only from the end of a complete bus cycle. The bench holds the event input high across the whole write, releases it, then issues two more mask writes. The first must read the bit as set again and the second as clear. A related case is an interrupt with a bit still latched while its mask goes off and on. The bench reaches it by rewriting the mask register between event pulses and status clears.

// File: rtl/hostport_pkg.sv
package hostport_pkg;
  parameter int HP_DW = 8;

  parameter logic [HP_DW-1:0] ADR_STAT_A = 8'h00;
  parameter logic [HP_DW-1:0] ADR_STAT_B = 8'h01;
  parameter logic [HP_DW-1:0] ADR_MASK_A = 8'h02;
  parameter logic [HP_DW-1:0] ADR_MASK_B = 8'h03;
  parameter logic [HP_DW-1:0] ADR_RT     = 8'h04;
endpackage

// File: rtl/hp_bus_decode.sv
module hp_bus_decode
  import hostport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_mode,
  input  logic             cs_n,
  input  logic             ale,
  input  logic             rd_n_ds,
  input  logic             wr_n_rw,
  input  logic [HP_DW-1:0] ad_in,
  output logic [HP_DW-1:0] addr_q,
  output logic [HP_DW-1:0] wdata_q,
  output logic             wr_commit,
  output logic             rd_act
);
  logic ale_q;
  logic wr_act, wr_act_q;
  logic addr_en;
  logic [HP_DW-1:0] addr_d, wdata_d;

  // strobe decode per timing style
  always_comb begin
    if (bus_mode) begin
      rd_act = !cs_n && rd_n_ds && wr_n_rw;
      wr_act = !cs_n && rd_n_ds && !wr_n_rw;
    end else begin
      rd_act = !cs_n && !rd_n_ds;
      wr_act = !cs_n && !wr_n_rw;
    end
  end

  assign addr_en   = ale_q && !ale;
  assign wr_commit = wr_act_q && !wr_act;

  always_comb begin
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (addr_en) addr_d  = ad_in;
    if (wr_act)  wdata_d = ad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q    <= 1'b0;
      wr_act_q <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      ale_q    <= ale;
      wr_act_q <= wr_act;
      addr_q   <= addr_d;
      wdata_q  <= wdata_d;
    end
  end
endmodule

// File: rtl/hp_stat_reg.sv
module hp_stat_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] irq_mask,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] copy_q,
  output logic         irq_n
);
  logic [W-1:0] latch_d, copy_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      latch_d[i] = latch_q[i] | evt[i];
      copy_d[i]  = copy_q[i];
      if (clr_en && clr_mask[i]) begin
        copy_d[i]  = latch_q[i] | evt[i];
        latch_d[i] = evt[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        latch_q[i] <= 1'b0;
        copy_q[i]  <= 1'b0;
      end else begin
        latch_q[i] <= latch_d[i];
        copy_q[i]  <= copy_d[i];
      end
    end
  end

  assign irq_n = ~|(latch_q & irq_mask);
endmodule

// File: rtl/hostport_top.sv
module hostport_top
  import hostport_pkg::*;
#(
  parameter int STA_W = 8,
  parameter int STB_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_mode,
  input  logic             cs_n,
  input  logic             ale,
  input  logic             rd_n_ds,
  input  logic             wr_n_rw,
  input  logic [HP_DW-1:0] ad_in,
  output logic [HP_DW-1:0] ad_out,
  output logic             ad_oe,
  input  logic [STA_W-1:0] evt_a,
  input  logic [STB_W-1:0] evt_b,
  input  logic [HP_DW-1:0] rt_status,
  output logic             irq_a_n,
  output logic             irq_b_n
);
  logic [HP_DW-1:0] addr_q, wdata_q;
  logic             wr_commit, rd_act;
  logic [STA_W-1:0] mask_a_q, mask_a_d, latch_a, copy_a;
  logic [STB_W-1:0] mask_b_q, mask_b_d, latch_b, copy_b;
  logic             clr_a, clr_b;
  logic [HP_DW-1:0] rdata, ad_out_d;
  logic             ad_oe_d;

  hp_bus_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_mode (bus_mode),
    .cs_n     (cs_n),
    .ale      (ale),
    .rd_n_ds  (rd_n_ds),
    .wr_n_rw  (wr_n_rw),
    .ad_in    (ad_in),
    .addr_q   (addr_q),
    .wdata_q  (wdata_q),
    .wr_commit(wr_commit),
    .rd_act   (rd_act)
  );

  assign clr_a = wr_commit && (addr_q == ADR_STAT_A);
  assign clr_b = wr_commit && (addr_q == ADR_STAT_B);

  hp_stat_reg #(.W(STA_W)) u_stat_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt_a),
    .clr_en  (clr_a),
    .clr_mask(wdata_q[STA_W-1:0]),
    .irq_mask(mask_a_q),
    .latch_q (latch_a),
    .copy_q  (copy_a),
    .irq_n   (irq_a_n)
  );

  hp_stat_reg #(.W(STB_W)) u_stat_b (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt_b),
    .clr_en  (clr_b),
    .clr_mask(wdata_q[STB_W-1:0]),
    .irq_mask(mask_b_q),
    .latch_q (latch_b),
    .copy_q  (copy_b),
    .irq_n   (irq_b_n)
  );

  // mask registers
  always_comb begin
    mask_a_d = mask_a_q;
    mask_b_d = mask_b_q;
    if (wr_commit && addr_q == ADR_MASK_A) mask_a_d = wdata_q[STA_W-1:0];
    if (wr_commit && addr_q == ADR_MASK_B) mask_b_d = wdata_q[STB_W-1:0];
  end

  // read selection, zero-extended
  always_comb begin
    rdata = '0;
    case (addr_q)
      ADR_STAT_A: rdata[STA_W-1:0] = copy_a;
      ADR_STAT_B: rdata[STB_W-1:0] = copy_b;
      ADR_MASK_A: rdata[STA_W-1:0] = mask_a_q;
      ADR_MASK_B: rdata[STB_W-1:0] = mask_b_q;
      ADR_RT:     rdata            = rt_status;
      default:    rdata            = '0;
    endcase
  end

  always_comb begin
    ad_oe_d  = rd_act;
    ad_out_d = ad_out;
    if (rd_act) ad_out_d = rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_a_q <= '0;
      mask_b_q <= '0;
      ad_oe    <= 1'b0;
      ad_out   <= '0;
    end else begin
      mask_a_q <= mask_a_d;
      mask_b_q <= mask_b_d;
      ad_oe    <= ad_oe_d;
      ad_out   <= ad_out_d;
    end
  end
endmodule

// File: rtl/hp_port_chk.sv
module hp_port_chk
  import hostport_pkg::*;
#(
  parameter int STA_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             ad_oe,
  input logic [HP_DW-1:0] ad_out,
  input logic [STA_W-1:0] evt_a,
  input logic [HP_DW-1:0] rt_status,
  input logic             irq_a_n,
  input logic [HP_DW-1:0] addr_q,
  input logic             wr_commit,
  input logic             rd_act,
  input logic [STA_W-1:0] mask_a_q,
  input logic [STA_W-1:0] latch_a
);
  // R4: bus is driven only after a selected cycle
  p_oe_needs_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> $past(!cs_n));

  // R9: an unmasked event pulls the interrupt low on the next cycle
  p_irq_fires_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(evt_a & mask_a_q)) && !wr_commit) |=> !irq_a_n);

  // R5: latched bits stay set while no write commits
  p_latch_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> ((latch_a & $past(latch_a)) == $past(latch_a)));

  // R8: real-time register returns the live input
  p_rt_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && addr_q == ADR_RT) |=> (ad_out == $past(rt_status)));

  // R10: unassigned high bits of the B registers read zero
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && (addr_q == ADR_STAT_B || addr_q == ADR_MASK_B)) |=> (ad_out[7:6] == 2'b00));
endmodule

bind hostport_top hp_port_chk #(.STA_W(STA_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .ad_oe    (ad_oe),
  .ad_out   (ad_out),
  .evt_a    (evt_a),
  .rt_status(rt_status),
  .irq_a_n  (irq_a_n),
  .addr_q   (addr_q),
  .wr_commit(wr_commit),
  .rd_act   (rd_act),
  .mask_a_q (mask_a_q),
  .latch_a  (latch_a)
);

// File: tb/hostport_top_tb_top.sv
module hostport_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {mode, addr, wdata, expected readback}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 8'h02, 8'hA5, 8'hA5},
    {1'b1, 8'h02, 8'h3C, 8'h3C},
    {1'b0, 8'h03, 8'hFF, 8'h3F},
    {1'b1, 8'h03, 8'hC1, 8'h01},
    {1'b1, 8'h02, 8'h00, 8'h00},
    {1'b0, 8'h03, 8'h2A, 8'h2A},
    {1'b1, 8'h07, 8'h77, 8'h00},
    {1'b0, 8'h06, 8'h55, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_mode = 1'b0;
  logic       cs_n = 1'b1;
  logic       ale = 1'b0;
  logic       rd_n_ds = 1'b1;
  logic       wr_n_rw = 1'b1;
  logic [7:0] ad_in = '0;
  logic [7:0] ad_out;
  logic       ad_oe;
  logic [7:0] evt_a = '0;
  logic [5:0] evt_b = '0;
  logic [7:0] rt_status = '0;
  logic       irq_a_n, irq_b_n;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostport_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n), .ale(ale),
    .rd_n_ds(rd_n_ds), .wr_n_rw(wr_n_rw), .ad_in(ad_in), .ad_out(ad_out),
    .ad_oe(ad_oe), .evt_a(evt_a), .evt_b(evt_b), .rt_status(rt_status),
    .irq_a_n(irq_a_n), .irq_b_n(irq_b_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_idle(input bit mode);
    rd_n_ds = mode ? 1'b0 : 1'b1;
    wr_n_rw = 1'b1;
  endtask

  task automatic bus_cycle(input bit mode, input bit is_wr, input logic [7:0] addr,
                           input logic [7:0] wdata, output logic [7:0] rdata);
    @(negedge clk);
    cs_n = 1'b1; bus_mode = mode; set_idle(mode);
    ale = 1'b1; ad_in = addr;
    @(negedge clk);
    cs_n = 1'b0; ale = 1'b0;
    @(negedge clk);
    ad_in = is_wr ? wdata : ~addr;
    if (mode) begin
      wr_n_rw = !is_wr; rd_n_ds = 1'b1;
    end else if (is_wr) begin
      wr_n_rw = 1'b0;
    end else begin
      rd_n_ds = 1'b0;
    end
    repeat (2) @(negedge clk);
    rdata = ad_out;
    @(negedge clk);
    set_idle(mode);
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic wr(input bit mode, input logic [7:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    bus_cycle(mode, 1'b1, a, d, dummy);
  endtask

  task automatic rdreg(input bit mode, input logic [7:0] a, output logic [7:0] d);
    bus_cycle(mode, 1'b0, a, 8'h00, d);
  endtask

  task automatic pulse_a(input logic [7:0] v);
    @(negedge clk); evt_a = v;
    @(negedge clk); evt_a = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 oe", {7'd0, ad_oe}, 8'h00);
    check("R1 irq_a", {7'd0, irq_a_n}, 8'h01);
    check("R1 irq_b", {7'd0, irq_b_n}, 8'h01);
    rdreg(0, 8'h00, rd); check("R1 stat_a", rd, 8'h00);
    rdreg(0, 8'h01, rd); check("R1 stat_b", rd, 8'h00);
    rdreg(1, 8'h02, rd); check("R1 mask_a", rd, 8'h00);
    rdreg(1, 8'h03, rd); check("R1 mask_b", rd, 8'h00);

    // R3 R10 vector table, both timing styles
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][24], VEC[i][23:16], VEC[i][15:8]);
      rdreg(!VEC[i][24], VEC[i][23:16], rd);
      check("R3/R10 vector", rd, VEC[i][7:0]);
    end

    // R4 output enable timing (mode 0)
    wr(0, 8'h03, 8'h00);
    @(negedge clk); bus_mode = 0; set_idle(0); ale = 1; ad_in = 8'h03;
    @(negedge clk); cs_n = 0; ale = 0;
    @(negedge clk); rd_n_ds = 0;
    check("R4 oe before edge", {7'd0, ad_oe}, 8'h00);
    @(negedge clk);
    check("R4 oe rises", {7'd0, ad_oe}, 8'h01);
    rd_n_ds = 1;
    check("R4 oe held", {7'd0, ad_oe}, 8'h01);
    @(negedge clk);
    check("R4 oe falls", {7'd0, ad_oe}, 8'h00);
    cs_n = 1;

    // R5 R6 latch and masked copy update
    pulse_a(8'h05);
    rdreg(0, 8'h00, rd); check("R6 copy held before write", rd, 8'h00);
    wr(0, 8'h00, 8'h01); rdreg(0, 8'h00, rd); check("R5 bit0 latched", rd, 8'h01);
    wr(1, 8'h00, 8'h04); rdreg(1, 8'h00, rd); check("R6 zero bits keep copy", rd, 8'h05);
    wr(0, 8'h00, 8'h01); rdreg(0, 8'h00, rd); check("R6 bit0 cleared", rd, 8'h04);
    wr(0, 8'h00, 8'h04); rdreg(0, 8'h00, rd); check("R6 bit2 cleared", rd, 8'h00);

    // R9 interrupt and masking
    wr(0, 8'h02, 8'h10);
    pulse_a(8'h08);
    check("R9 masked event no irq", {7'd0, irq_a_n}, 8'h01);
    pulse_a(8'h10);
    check("R9 irq asserts", {7'd0, irq_a_n}, 8'h00);
    wr(0, 8'h00, 8'h10);
    @(negedge clk); check("R9 irq clears", {7'd0, irq_a_n}, 8'h01);
    pulse_a(8'h10);
    check("R9 irq asserts again", {7'd0, irq_a_n}, 8'h00);
    wr(1, 8'h02, 8'h00);
    @(negedge clk); check("R9 masked off", {7'd0, irq_a_n}, 8'h01);
    wr(1, 8'h02, 8'h10);
    @(negedge clk); check("R9 unmasked again", {7'd0, irq_a_n}, 8'h00);
    wr(0, 8'h00, 8'hFF);
    @(negedge clk); check("R9 cleared all", {7'd0, irq_a_n}, 8'h01);
    wr(0, 8'h00, 8'hFF); rdreg(0, 8'h00, rd); check("R6 all clear", rd, 8'h00);

    // R7 event present during clear
    @(negedge clk); evt_a = 8'h08;
    wr(0, 8'h00, 8'h08);
    @(negedge clk); evt_a = 8'h00;
    wr(0, 8'h00, 8'h08); rdreg(0, 8'h00, rd); check("R7 set again", rd, 8'h08);
    wr(1, 8'h00, 8'h08); rdreg(1, 8'h00, rd); check("R7 finally clear", rd, 8'h00);

    // R8 real-time status, R2 address held after strobe
    @(negedge clk); rt_status = 8'h3C;
    rdreg(0, 8'h04, rd); check("R8 rt mode0", rd, 8'h3C);
    @(negedge clk); rt_status = 8'hA5;
    rdreg(1, 8'h04, rd); check("R2/R8 rt mode1 addr kept", rd, 8'hA5);

    // R10 status B narrow width, irq B
    wr(1, 8'h03, 8'hFF); rdreg(1, 8'h03, rd); check("R10 mask_b width", rd, 8'h3F);
    @(negedge clk); evt_b = 6'h3F;
    @(negedge clk); evt_b = 6'h00;
    check("R9 irq_b asserts", {7'd0, irq_b_n}, 8'h00);
    wr(0, 8'h01, 8'hFF); rdreg(0, 8'h01, rd); check("R10 stat_b width", rd, 8'h3F);
    check("R9 irq_b clears", {7'd0, irq_b_n}, 8'h01);

    // R3 a read does not modify the mask
    rdreg(1, 8'h02, rd); rdreg(1, 8'h02, rd); check("R3 read no write", rd, 8'h10);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule